// File: doc/BRIEF.md
# Bidirectional Ring Segment Arbiter

This block decides which pending transfers may use an on-chip interconnect made of four data rings. Two of the rings carry data clockwise and two carry it counterclockwise. Twelve nodes sit at fixed positions around the rings. Position p is followed clockwise by position p+1, and position 11 wraps back to 0. Each ring is 16 bytes wide. Only the routing and occupancy of its segments are handled here, not the data.

A node raises its request bit and supplies a destination position and a length in beats. In a single cycle the arbiter finds the first requester, in rotating priority order, whose transfer fits. It then reports a one-hot grant together with the ring chosen. The transfer claims every hop between source and destination in the chosen direction for its length, and the hops are freed when the length expires. The requester keeps its bit high until it sees its grant, and drops it after that clock edge.

Top module: `ring_seg_arb`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle. It is high only for a node whose request is valid and legal. A grant is taken at the rising clock edge that ends the cycle in which it is shown.
- R2: Segment k of ring r is hop k↔k+1 (mod 12) and is reported on `seg_busy[r*12+k]`. A clockwise transfer from s to d claims segments s..d-1. A counterclockwise one claims segments d..s-1, with wrap-around in both cases.
- R3: Let h = (d − s) mod 12. If h < 6, only clockwise rings are tried. If h > 6, only counterclockwise rings are tried. If h = 6, clockwise is tried first and counterclockwise second. No grant ever spans more than 6 hops.
- R4: `gnt_ring` values 0 and 1 are the clockwise rings and values 2 and 3 are the counterclockwise rings. Within a direction the lower-numbered ring is tried first. `gnt_ring` is 0 when there is no grant.
- R5: A ring is chosen only if none of the segments the transfer needs are already held on that ring. Transfers held on one ring never share a segment.
- R6: A ring holds at most three transfers at once, even when free segments remain.
- R7: The search starts at a pointer that is 0 after reset. After each grant the pointer becomes the winner's position plus one (mod 12). A requester that cannot be placed is skipped, and the next one in order may win.
- R8: A grant holds its segments for L cycles after the accepting edge and then frees them. L is `req_len` of the winner, and a value of 0 means 8.
- R9: A request whose destination equals its own position, or is 12 or more, raises that node's `err` bit in the same cycle. It is never granted and claims nothing.
- R10: While `rst` is high, `gnt` and `err` are 0. After reset all segments are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 12 | Request bit per node position |
| req_dst | input | 48 | Destination position, 4 bits per node |
| req_len | input | 60 | Hold length in cycles, 5 bits per node, 0 selects 8 |
| gnt | output | 12 | One-hot grant to the winning node |
| gnt_ring | output | 2 | Ring given to the winner |
| err | output | 12 | Illegal-destination flag per node |
| seg_busy | output | 48 | Held segments, 12 per ring |

## Verification
Rejecting an illegal request and granting a legal one can happen in the same cycle. The bench provokes this by raising a self-addressed request together with a valid request from another node. In that cycle it expects exactly the error bit of the first node and the grant of the second. It then holds the bad request alone and checks that no grant appears and that, once the legal transfer has timed out, no segment remains held.

// File: rtl/ring_seg_arb.sv
module ring_seg_arb #(
  parameter int N      = 12,
  parameter int RPD    = 2,
  parameter int SLOTS  = 3,
  parameter int LW     = 5,
  parameter int DEFLEN = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0]              req_valid,
  input  logic [N*$clog2(N)-1:0]    req_dst,
  input  logic [N*LW-1:0]           req_len,
  output logic [N-1:0]              gnt,
  output logic [$clog2(2*RPD)-1:0]  gnt_ring,
  output logic [N-1:0]              err,
  output logic [2*RPD*N-1:0]        seg_busy
);
  localparam int NW   = $clog2(N);
  localparam int NR   = 2 * RPD;
  localparam int RW   = $clog2(NR);
  localparam int MAXH = N / 2;
  localparam int CW   = $clog2(SLOTS + 1);
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  function automatic logic [N-1:0] span(input int start, input int len);
    span = '0;
    for (int k = 0; k < N; k++)
      if (k < len) span[(start + k) % N] = 1'b1;
  endfunction

  logic [NW-1:0]  ptr;
  logic           slot_v [NR][SLOTS];
  logic [N-1:0]   slot_m [NR][SLOTS];
  logic [LW-1:0]  slot_t [NR][SLOTS];
  logic [N-1:0]   busy   [NR];
  logic [CW-1:0]  cnt    [NR];
  logic [N-1:0]   bad, ok;
  logic [RW-1:0]  pr [N];
  logic [N-1:0]   pm [N];
  logic           found;
  logic [NW-1:0]  win;
  logic [SW-1:0]  fs;
  logic [LW-1:0]  wlen, glen;

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      busy[r] = '0;
      cnt[r]  = '0;
      for (int s = 0; s < SLOTS; s++)
        if (slot_v[r][s]) begin
          busy[r] = busy[r] | slot_m[r][s];
          cnt[r]  = cnt[r] + CW'(1);
        end
    end
  end

  always_comb begin
    int d, h;
    logic [N-1:0] mcw, mccw, m;
    logic cc, allow;
    for (int i = 0; i < N; i++) begin
      d      = int'(req_dst[i*NW +: NW]);
      bad[i] = (d == i) || (d >= N);
      h      = (d >= i) ? d - i : d + N - i;
      mcw    = span(i, h);
      mccw   = span(d % N, N - h);
      ok[i]  = 1'b0;
      pr[i]  = '0;
      pm[i]  = '0;
      for (int r = 0; r < NR; r++) begin
        cc    = (r >= RPD);
        allow = cc ? (h >= MAXH) : (h <= MAXH);
        m     = cc ? mccw : mcw;
        if (!ok[i] && allow && ((busy[r] & m) == '0) && (int'(cnt[r]) < SLOTS)) begin
          ok[i] = 1'b1;
          pr[i] = RW'(r);
          pm[i] = m;
        end
      end
    end
  end

  always_comb begin
    int j;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr) + k) % N;
      if (!found && req_valid[j] && !bad[j] && ok[j]) begin
        found = 1'b1;
        win   = NW'(j);
      end
    end
  end

  always_comb begin
    logic got;
    got = 1'b0;
    fs  = '0;
    for (int s = 0; s < SLOTS; s++)
      if (!got && !slot_v[pr[win]][s]) begin
        got = 1'b1;
        fs  = SW'(s);
      end
  end

  assign wlen     = req_len[int'(win)*LW +: LW];
  assign glen     = (wlen == '0) ? LW'(DEFLEN) : wlen;
  assign gnt      = (found && !rst) ? ({{(N-1){1'b0}}, 1'b1} << win) : '0;
  assign gnt_ring = (found && !rst) ? pr[win] : '0;
  assign err      = rst ? '0 : (req_valid & bad);

  for (genvar r = 0; r < NR; r++) begin : g_out
    assign seg_busy[r*N +: N] = busy[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      for (int r = 0; r < NR; r++)
        for (int s = 0; s < SLOTS; s++) slot_v[r][s] <= 1'b0;
    end else begin
      if (found) ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
      for (int r = 0; r < NR; r++)
        for (int s = 0; s < SLOTS; s++)
          if (found && int'(pr[win]) == r && int'(fs) == s) begin
            slot_v[r][s] <= 1'b1;
            slot_m[r][s] <= pm[win];
            slot_t[r][s] <= glen;
          end else if (slot_v[r][s]) begin
            if (slot_t[r][s] == LW'(1)) slot_v[r][s] <= 1'b0;
            else slot_t[r][s] <= slot_t[r][s] - 1'b1;
          end
    end
  end

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  assert_no_err_grant_R9: assert property (@(posedge clk) disable iff (rst) (gnt & err) == '0);
  assert_grant_claims_R2: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |=> ((seg_busy & ~$past(seg_busy)) != '0));

  for (genvar r = 0; r < NR; r++) begin : g_chk
    for (genvar a = 0; a < SLOTS; a++) begin : g_a
      assert_hop_limit_R3: assert property (@(posedge clk) disable iff (rst)
        slot_v[r][a] |-> ($countones(slot_m[r][a]) <= MAXH && slot_m[r][a] != '0));
      for (genvar b = a + 1; b < SLOTS; b++) begin : g_b
        assert_disjoint_R5: assert property (@(posedge clk) disable iff (rst)
          (slot_v[r][a] && slot_v[r][b]) |-> ((slot_m[r][a] & slot_m[r][b]) == '0));
      end
    end
  end
endmodule

// File: tb/tb_ring_seg_arb.sv
module tb_ring_seg_arb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] req_valid = '0;
  logic [47:0] req_dst = '0;
  logic [59:0] req_len = '0;
  logic [11:0] gnt;
  logic [1:0]  gnt_ring;
  logic [11:0] err;
  logic [47:0] seg_busy;
  int checks = 0;
  int fails = 0;

  ring_seg_arb dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst),
    .req_len(req_len), .gnt(gnt), .gnt_ring(gnt_ring), .err(err), .seg_busy(seg_busy));

  always #2 clk = ~clk;

  // src, dst, ring, mask
  localparam logic [21:0] VEC [7] = '{
    {4'd0,  4'd3,  2'd0, 12'h007},
    {4'd5,  4'd2,  2'd2, 12'h01C},
    {4'd2,  4'd8,  2'd0, 12'h0FC},
    {4'd11, 4'd1,  2'd0, 12'h801},
    {4'd1,  4'd11, 2'd2, 12'h801},
    {4'd7,  4'd0,  2'd0, 12'hF80},
    {4'd0,  4'd7,  2'd2, 12'hF80}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int s, input int d, input int len);
    req_dst[s*4 +: 4] = 4'(d);
    req_len[s*5 +: 5] = 5'(len);
    req_valid[s] = 1'b1;
  endtask

  task automatic clr_req(input int s);
    req_valid[s] = 1'b0;
  endtask

  task automatic do_reset();
    req_valid = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic one(input int s, input int d, input int len, input bit expg,
                     input int ring, input string tag);
    @(negedge clk);
    set_req(s, d, len);
    #1;
    chk({tag, " gnt"}, 64'(gnt), expg ? 64'(12'b1 << s) : 64'd0);
    chk({tag, " ring"}, 64'(gnt_ring), expg ? 64'(ring) : 64'd0);
    @(posedge clk);
    #1 clr_req(s);
  endtask

  task automatic finish_all();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_all();
  end

  initial begin
    // R10: outputs quiet in reset even with a request present
    set_req(0, 1, 1);
    #1 chk("R10 gnt in reset", 64'(gnt), 0);
    set_req(3, 3, 1);
    #1 chk("R10 err in reset", 64'(err), 0);
    do_reset();
    #1 chk("R10 busy after reset", 64'(seg_busy), 0);

    // R2 R3 R4 vector walk, length 1
    do_reset();
    foreach (VEC[v]) begin
      one(int'(VEC[v][21:18]), int'(VEC[v][17:14]), 1, 1'b1, int'(VEC[v][13:12]), "R3 R4 vec");
      @(negedge clk); #1;
      chk("R2 vec segments", 64'(seg_busy), 64'(48'(VEC[v][11:0]) << (12 * int'(VEC[v][13:12]))));
      @(negedge clk); #1;
      chk("R8 vec release", 64'(seg_busy), 0);
    end

    // R3 R4 R5: tie fallback, no long route for short request
    do_reset();
    one(2, 8, 20, 1'b1, 0, "R4 tie ring0");
    one(2, 8, 20, 1'b1, 1, "R4 tie ring1");
    one(3, 5, 20, 1'b0, 0, "R3 short not rerouted");
    one(2, 8, 20, 1'b1, 2, "R3 tie to ccw");
    #1 chk("R2 ccw tie segments", 64'(seg_busy),
           64'((48'h0FC) | (48'h0FC << 12) | (48'hF03 << 24)));
    one(2, 8, 20, 1'b1, 3, "R4 ccw ring3");
    one(2, 8, 20, 1'b0, 0, "R5 all rings held");

    // R5: overlap pushes to next ring, gap reused on ring0
    do_reset();
    one(0, 3, 31, 1'b1, 0, "R5 first");
    one(2, 4, 31, 1'b1, 1, "R5 overlap to ring1");
    one(3, 5, 31, 1'b1, 0, "R5 fits ring0");
    #1 chk("R5 segments", 64'(seg_busy), 64'(48'h01F | (48'h00C << 12)));

    // R6: three per ring
    do_reset();
    for (int k = 0; k < 6; k++) one(k, k + 1, 31, 1'b1, (k < 3) ? 0 : 1, "R6 fill");
    one(6, 7, 31, 1'b0, 0, "R6 cap reached");
    one(8, 7, 31, 1'b1, 2, "R6 ccw unaffected");
    #1 chk("R6 segments", 64'(seg_busy),
           64'(48'h007 | (48'h038 << 12) | (48'h080 << 24)));

    // R7 R1: round robin
    do_reset();
    @(negedge clk);
    set_req(3, 4, 31); set_req(9, 10, 31);
    #1 chk("R1 R7 first from pointer 0", 64'(gnt), 64'(12'b1 << 3));
    @(posedge clk); #1 clr_req(3); set_req(1, 2, 31);
    @(negedge clk); #1 chk("R1 R7 rotate past 3", 64'(gnt), 64'(12'b1 << 9));
    @(posedge clk); #1 clr_req(9); set_req(5, 6, 31);
    @(negedge clk); #1 chk("R7 wrap to 1", 64'(gnt), 64'(12'b1 << 1));
    @(posedge clk); #1 clr_req(1);
    @(negedge clk); #1 chk("R7 then 5", 64'(gnt), 64'(12'b1 << 5));
    @(posedge clk); #1 clr_req(5);

    // R9: error and grant in one cycle
    do_reset();
    @(negedge clk);
    set_req(4, 4, 1); set_req(6, 7, 1);
    #1 chk("R9 err self", 64'(err), 64'(12'b1 << 4));
    chk("R9 legal granted", 64'(gnt), 64'(12'b1 << 6));
    @(posedge clk); #1 clr_req(6);
    @(negedge clk); #1 chk("R9 self never granted", 64'(gnt), 0);
    chk("R9 err held", 64'(err), 64'(12'b1 << 4));
    @(posedge clk); #1 clr_req(4); set_req(5, 13, 1);
    @(negedge clk); #1 chk("R9 err range", 64'(err), 64'(12'b1 << 5));
    chk("R9 range no grant", 64'(gnt), 0);
    @(posedge clk); #1 clr_req(5);
    @(negedge clk); #1 chk("R9 nothing claimed", 64'(seg_busy), 0);

    // R8: default and explicit length
    do_reset();
    one(0, 2, 0, 1'b1, 0, "R8 default");
    for (int c = 0; c < 9; c++) begin
      @(negedge clk); #1;
      chk("R8 default hold", 64'(seg_busy), (c < 8) ? 64'h003 : 64'd0);
    end
    one(4, 5, 3, 1'b1, 0, "R8 len3");
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      chk("R8 len3 hold", 64'(seg_busy), (c < 3) ? 64'h010 : 64'd0);
    end

    finish_all();
  end
endmodule